// File: doc/BRIEF.md
# Eight-Line Interrupt Controller with Non-Maskable Line

This block sits beside a small processor core and decides which of eight interrupt request lines the core services next. Each request is captured in a pending register. An 8-bit enable mask filters the pending set, and a fixed priority encoder picks the winner: the lowest-numbered line wins. The controller keeps its own in-service record. In the default nested policy, a new interrupt is taken only when it outranks every line already in service. In the optional sequential policy, the processor's I bit alone gates entry, so nothing starts while that bit is set. When the controller takes an interrupt it raises a one-cycle take strobe and presents a 3-bit line index. The core uses these to fetch its vector and save its context. Each ISR-exit pulse retires the highest-priority in-service line.

Several features are set by elaboration parameters. Line 0 can be tied permanently enabled, which makes it non-maskable. Mask writes can be privileged, so that they land only while the I bit is set. The core can ask to wait. In halting mode the controller holds the core stalled until an interrupt is taken, and raises no interrupt of its own. Otherwise the wait request gives a fixed burst of idle cycles, 5 by default.

Top module: `intc8_top`

## Requirements
- R1: After reset, mask_o equals the MASK_RESET parameter (default 8'hFF). When NMI_ON is set, bit 0 reads as 1. When NMI_ON is clear, bit 0 is kept as given, so a reset value of 8'h5A leaves line 0 masked.
- R2: With NMI_ON set, mask_o[0] is always 1 whatever value is written. A request on line 0 is taken even after a mask write of 8'h00.
- R3: Mask bit n = 1 enables line n. A pending request on a masked line is never taken. It stays pending, and it is taken once its mask bit is set.
- R4: When take_o is high, vec_o is the lowest line index among the lines that are both pending and enabled.
- R5: A request held for a single cycle is latched as pending. take_o appears in the cycle after the request is sampled. The pending bit clears on the take edge, so each request is taken exactly once.
- R6: With SEQ_MODE clear, an interrupt is taken only if its index is lower than the index of every line in service. Each take adds its line to the in-service set. Each isr_exit_i pulse removes the lowest-numbered in-service line.
- R7: With SEQ_MODE set, take_o stays low while ibit_i is 1, even for line 0. It rises in the same cycle that ibit_i falls if an enabled request is pending.
- R8: With PRIV_MASK set, a mask write while ibit_i is 0 leaves mask_o unchanged. A mask write while ibit_i is 1 updates it on the next edge.
- R9: With WAIT_HALTS set, halt_o rises on the edge after wait_req_i and stays high through the cycle in which take_o is high. It falls on the edge that consumes the take.
- R10: With WAIT_HALTS clear, a wait_req_i pulse drives halt_o high for exactly IDLE_CYCLES cycles (default 5), and no interrupt is taken because of it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 8 | Interrupt request lines, bit n is line n |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_data_i | input | 8 | Data for a mask write |
| ibit_i | input | 1 | Processor I (interrupt in progress) flag |
| wait_req_i | input | 1 | Request to enter the wait state |
| isr_exit_i | input | 1 | Pulse when the core leaves an ISR |
| take_o | output | 1 | One-cycle strobe: an interrupt is being taken |
| vec_o | output | 3 | Index of the line being taken |
| halt_o | output | 1 | Core stall request |
| mask_o | output | 8 | Effective enable mask |

## Verification
A pending bit that is lost or left stuck shows up at the ports within one or two cycles. A pulsed request then never raises take_o, or it raises take_o a second time after the exit pulse that should have ended it. A corrupted in-service record shows up after the next isr_exit_i: a lower-priority line is taken too early, or it stays blocked. The directed scenarios chain takes and exits so that every such slip changes the very next sample of take_o and vec_o. A mask register that ignores the privilege or forcing rules is visible at mask_o one edge after the write. Wait-state errors appear as a halt_o pulse whose length differs from the expected count, or that outlives the take strobe.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int LINES = 8;
  localparam int IDX_W = $clog2(LINES);

  // Index of the lowest set bit; LINES when the vector is empty.
  function automatic logic [IDX_W:0] first_idx(input logic [LINES-1:0] v);
    logic [IDX_W:0] r;
    r = (IDX_W+1)'(LINES);
    for (int i = LINES - 1; i >= 0; i--) begin
      if (v[i]) r = (IDX_W+1)'(i);
    end
    return r;
  endfunction

  // Bits strictly below position idx set to one.
  function automatic logic [LINES-1:0] below_mask(input logic [IDX_W-1:0] idx);
    logic [LINES-1:0] r;
    for (int i = 0; i < LINES; i++) r[i] = (i < int'(idx));
    return r;
  endfunction

  // One-hot form of an index, zero when en is low.
  function automatic logic [LINES-1:0] onehot(input logic en, input logic [IDX_W-1:0] idx);
    logic [LINES-1:0] r;
    r = '0;
    if (en) r[idx] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/intc_mask_reg.sv
module intc_mask_reg
  import intc_pkg::*;
#(
  parameter logic [LINES-1:0] MASK_RESET = '1,
  parameter bit               NMI_ON     = 1'b1,
  parameter bit               PRIV_MASK  = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [LINES-1:0] data_i,
  input  logic             ibit_i,
  output logic [LINES-1:0] mask_o
);
  localparam logic [LINES-1:0] FORCE_BITS = {{(LINES-1){1'b0}}, NMI_ON};
  localparam logic [LINES-1:0] RST_VAL    = MASK_RESET | FORCE_BITS;

  logic [LINES-1:0] mask_q;
  logic             wr_ok;

  assign wr_ok = wr_i && (!PRIV_MASK || ibit_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mask_q <= RST_VAL;
    else if (wr_ok) mask_q <= data_i | FORCE_BITS;
  end

  assign mask_o = mask_q;

  generate
    if (NMI_ON) begin : g_nmi_chk
      assert_nmi_forced_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mask_o[0]);
    end
    if (PRIV_MASK) begin : g_priv_chk
      assert_priv_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !ibit_i) |=> $stable(mask_o));
    end
  endgenerate
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
#(
  parameter bit SEQ_MODE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] req_i,
  input  logic [LINES-1:0] mask_i,
  input  logic             ibit_i,
  input  logic             exit_i,
  output logic             take_o,
  output logic [IDX_W-1:0] vec_o
);
  logic [LINES-1:0] pend_q;
  logic [LINES-1:0] ins_q;
  logic [LINES-1:0] ready;
  logic [IDX_W:0]   win_idx;
  logic [IDX_W:0]   ins_top;
  logic             has_win;
  logic             prio_ok;
  logic             gate_ok;
  logic [LINES-1:0] take_vec;
  logic [LINES-1:0] exit_vec;

  assign ready    = pend_q & mask_i;
  assign win_idx  = first_idx(ready);
  assign ins_top  = first_idx(ins_q);
  assign has_win  = (win_idx != (IDX_W+1)'(LINES));
  assign prio_ok  = (win_idx < ins_top);
  assign gate_ok  = SEQ_MODE ? !ibit_i : prio_ok;
  assign take_o   = has_win && gate_ok;
  assign vec_o    = win_idx[IDX_W-1:0];
  assign take_vec = onehot(take_o, vec_o);
  assign exit_vec = onehot(exit_i && (ins_q != '0), ins_top[IDX_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      ins_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~take_vec) | req_i;
      ins_q  <= (ins_q & ~exit_vec) | take_vec;
    end
  end

  assert_take_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (mask_i[vec_o] && pend_q[vec_o]));

  assert_lowest_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> ((ready & below_mask(vec_o)) == '0));

  assert_pend_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && !req_i[vec_o]) |=> !pend_q[$past(vec_o)]);

  generate
    if (SEQ_MODE) begin : g_seq_chk
      assert_seq_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ibit_i |-> !take_o);
    end else begin : g_nest_chk
      assert_nest_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> ((ins_q & below_mask(vec_o)) == '0) && !ins_q[vec_o]);
    end
  endgenerate
endmodule

// File: rtl/intc_wait_ctl.sv
module intc_wait_ctl #(
  parameter bit WAIT_HALTS  = 1'b0,
  parameter int IDLE_CYCLES = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wait_i,
  input  logic take_i,
  output logic halt_o
);
  localparam int CNT_W = $clog2(IDLE_CYCLES + 1);

  generate
    if (WAIT_HALTS) begin : g_halt
      logic halt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) halt_q <= 1'b0;
        else        halt_q <= wait_i || (halt_q && !take_i);
      end
      assign halt_o = halt_q;

      assert_wake_on_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !wait_i) |=> !halt_o);
      assert_halt_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wait_i |=> halt_o);
    end else begin : g_idle
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (wait_i)     cnt_q <= CNT_W'(IDLE_CYCLES);
        else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
      end
      assign halt_o = (cnt_q != '0);

      assert_idle_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wait_i |=> (cnt_q == CNT_W'(IDLE_CYCLES)));
      assert_idle_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(IDLE_CYCLES));
      // take_i only matters in halting mode; keep it referenced here.
      assert_idle_take_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !wait_i && cnt_q == '0) |=> !halt_o);
    end
  endgenerate
endmodule

// File: rtl/intc8_top.sv
module intc8_top
  import intc_pkg::*;
#(
  parameter logic [LINES-1:0] MASK_RESET  = '1,
  parameter bit               NMI_ON      = 1'b1,
  parameter bit               SEQ_MODE    = 1'b0,
  parameter bit               PRIV_MASK   = 1'b0,
  parameter bit               WAIT_HALTS  = 1'b0,
  parameter int               IDLE_CYCLES = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] req_i,
  input  logic             mask_wr_i,
  input  logic [LINES-1:0] mask_data_i,
  input  logic             ibit_i,
  input  logic             wait_req_i,
  input  logic             isr_exit_i,
  output logic             take_o,
  output logic [IDX_W-1:0] vec_o,
  output logic             halt_o,
  output logic [LINES-1:0] mask_o
);
  logic [LINES-1:0] mask_eff;
  logic             take_w;

  intc_mask_reg #(
    .MASK_RESET(MASK_RESET), .NMI_ON(NMI_ON), .PRIV_MASK(PRIV_MASK)
  ) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_i(mask_wr_i), .data_i(mask_data_i),
    .ibit_i(ibit_i), .mask_o(mask_eff)
  );

  intc_arbiter #(.SEQ_MODE(SEQ_MODE)) u_arb (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .mask_i(mask_eff),
    .ibit_i(ibit_i), .exit_i(isr_exit_i), .take_o(take_w), .vec_o(vec_o)
  );

  intc_wait_ctl #(.WAIT_HALTS(WAIT_HALTS), .IDLE_CYCLES(IDLE_CYCLES)) u_wait (
    .clk(clk), .rst_n(rst_n), .wait_i(wait_req_i), .take_i(take_w),
    .halt_o(halt_o)
  );

  assign take_o = take_w;
  assign mask_o = mask_eff;
endmodule

// File: tb/tb_intc8_top.sv
module tb_intc8_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // Instance A: defaults (line 0 forced, nested policy, idle wait).
  logic [7:0] a_req = '0, a_mdat = '0, a_mask;
  logic a_mwr = 0, a_ibit = 0, a_wait = 0, a_exit = 0, a_take, a_halt;
  logic [2:0] a_vec;
  // Instance B: line 0 maskable, sequential, privileged mask, halting wait.
  logic [7:0] b_req = '0, b_mdat = '0, b_mask;
  logic b_mwr = 0, b_ibit = 0, b_wait = 0, b_exit = 0, b_take, b_halt;
  logic [2:0] b_vec;

  intc8_top dut (
    .clk(clk), .rst_n(rst_n), .req_i(a_req), .mask_wr_i(a_mwr),
    .mask_data_i(a_mdat), .ibit_i(a_ibit), .wait_req_i(a_wait),
    .isr_exit_i(a_exit), .take_o(a_take), .vec_o(a_vec), .halt_o(a_halt),
    .mask_o(a_mask)
  );

  intc8_top #(
    .MASK_RESET(8'h5A), .NMI_ON(1'b0), .SEQ_MODE(1'b1), .PRIV_MASK(1'b1),
    .WAIT_HALTS(1'b1), .IDLE_CYCLES(5)
  ) dut_b (
    .clk(clk), .rst_n(rst_n), .req_i(b_req), .mask_wr_i(b_mwr),
    .mask_data_i(b_mdat), .ibit_i(b_ibit), .wait_req_i(b_wait),
    .isr_exit_i(b_exit), .take_o(b_take), .vec_o(b_vec), .halt_o(b_halt),
    .mask_o(b_mask)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_take(input logic t, input logic [2:0] v, input bit exp_t,
                            input int exp_v, input string tag);
    if (exp_t) check(t === 1'b1 && v === 3'(exp_v), tag, {t, v}, {1'b1, 3'(exp_v)});
    else       check(t === 1'b0, tag, t, 0);
  endtask

  task automatic a_pulse_req(input logic [7:0] v);
    a_req = v; tick(); a_req = '0;
  endtask
  task automatic a_pulse_exit();
    a_exit = 1; tick(); a_exit = 0;
  endtask
  task automatic a_write_mask(input logic [7:0] v);
    a_mwr = 1; a_mdat = v; tick(); a_mwr = 0;
  endtask
  task automatic b_pulse_exit();
    b_exit = 1; tick(); b_exit = 0;
  endtask
  task automatic b_write_mask(input logic [7:0] v);
    b_mwr = 1; b_mdat = v; tick(); b_mwr = 0;
  endtask

  task automatic t_reset();
    check(a_mask === 8'hFF, "R1 reset mask A", a_mask, 8'hFF);
    check(b_mask === 8'h5A, "R1 reset mask B", b_mask, 8'h5A);
    check_take(a_take, a_vec, 0, 0, "R5 no take after reset");
    check(a_halt === 1'b0 && b_halt === 1'b0, "R9 halt low after reset", {a_halt, b_halt}, 0);
  endtask

  task automatic t_nmi_and_mask();
    a_write_mask(8'h00);
    check(a_mask === 8'h01, "R2 bit0 forced", a_mask, 8'h01);
    a_pulse_req(8'h01);
    check_take(a_take, a_vec, 1, 0, "R2 line0 taken while mask cleared");
    tick(); a_pulse_exit();
    a_pulse_req(8'h08);
    check_take(a_take, a_vec, 0, 0, "R3 masked line3 not taken");
    tick();
    check_take(a_take, a_vec, 0, 0, "R3 masked line3 still held");
    a_write_mask(8'h08);
    check_take(a_take, a_vec, 1, 3, "R3 line3 taken after unmask");
    tick(); a_pulse_exit();
    a_write_mask(8'hFF);
  endtask

  task automatic t_priority_chain();
    a_pulse_req(8'b1010_0100);
    check_take(a_take, a_vec, 1, 2, "R4 lowest of 2,5,7 wins");
    tick();
    check_take(a_take, a_vec, 0, 0, "R6 line5 blocked by line2 in service");
    a_pulse_exit();
    check_take(a_take, a_vec, 1, 5, "R6 line5 after exit");
    tick(); a_pulse_exit();
    check_take(a_take, a_vec, 1, 7, "R4 line7 last");
    tick(); a_pulse_exit();
    check_take(a_take, a_vec, 0, 0, "R5 each request taken once");
  endtask

  task automatic t_nesting();
    a_pulse_req(8'h40);
    check_take(a_take, a_vec, 1, 6, "R6 line6 taken");
    tick();
    a_pulse_req(8'h02);
    check_take(a_take, a_vec, 1, 1, "R6 line1 preempts line6");
    tick();
    a_pulse_req(8'h80);
    check_take(a_take, a_vec, 0, 0, "R6 line7 below in-service set");
    a_pulse_exit();
    check_take(a_take, a_vec, 0, 0, "R6 exit retires line1, line6 still blocks");
    a_pulse_exit();
    check_take(a_take, a_vec, 1, 7, "R6 line7 after both exits");
    tick(); a_pulse_exit();
  endtask

  task automatic t_idle_wait();
    int n;
    a_wait = 1; tick(); a_wait = 0;
    n = 0;
    while (a_halt === 1'b1 && n < 12) begin
      n++;
      check_take(a_take, a_vec, 0, 0, "R10 no interrupt from idle wait");
      tick();
    end
    check(n == 5, "R10 idle burst length", n, 5);
  endtask

  task automatic t_b_mask_priv();
    b_req = 8'h01; tick(); b_req = '0;
    check_take(b_take, b_vec, 0, 0, "R1 line0 maskable when forcing off");
    b_ibit = 0; b_write_mask(8'hFF);
    check(b_mask === 8'h5A, "R8 write ignored with I clear", b_mask, 8'h5A);
    b_ibit = 1; b_write_mask(8'hFF);
    check(b_mask === 8'hFF, "R8 write accepted with I set", b_mask, 8'hFF);
    check_take(b_take, b_vec, 0, 0, "R7 line0 held while I set");
    b_ibit = 0; #1;
    check_take(b_take, b_vec, 1, 0, "R3 stale line0 taken once enabled");
    @(negedge clk); b_pulse_exit();
  endtask

  task automatic t_b_seq();
    b_ibit = 1;
    b_req = 8'h02; tick(); b_req = '0;
    check_take(b_take, b_vec, 0, 0, "R7 blocked while I set");
    tick();
    check_take(b_take, b_vec, 0, 0, "R7 still blocked");
    b_ibit = 0; #1;
    check_take(b_take, b_vec, 1, 1, "R7 taken when I falls");
    @(negedge clk); b_pulse_exit();
  endtask

  task automatic t_b_halt();
    b_wait = 1; tick(); b_wait = 0;
    check(b_halt === 1'b1, "R9 halt after wait", b_halt, 1);
    repeat (7) tick();
    check(b_halt === 1'b1, "R9 halt held without interrupt", b_halt, 1);
    b_req = 8'h10; tick(); b_req = '0;
    check_take(b_take, b_vec, 1, 4, "R9 wake interrupt taken");
    check(b_halt === 1'b1, "R9 halt high during take", b_halt, 1);
    tick();
    check(b_halt === 1'b0, "R9 halt released after take", b_halt, 0);
    b_pulse_exit();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_nmi_and_mask();
    t_priority_chain();
    t_nesting();
    t_idle_wait();
    t_b_mask_priv();
    t_b_seq();
    t_b_halt();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule